// File: doc/BRIEF.md
# Dual-Pool Buffer Carveout Allocator

This block hands out fixed 2 KiB slices of two staging memories to DMA channels. Transmit channels, which move data from memory to a device, draw from one pool. Receive channels, which move data from a device to memory, draw from the other. Each pool has its own occupancy bitmap. Each pool also has a byte size, loaded from a size input. The number of usable slices in a pool is that size divided by 2048, capped at 32.

A client raises a request with a direction flag and an operation flag. An allocation returns a packed carveout word: the slice size sits in the upper half and the byte offset of the slice in the lower half. If no slice is free, it returns a busy error. A release names a carveout word. The block uses the offset field to find the slice, clears it, and flags offsets that are out of range and slices that were never held. Every accepted request gets exactly one response, one cycle after acceptance.

Top module: `carveout_alloc`

## Requirements
- R1: After reset both pools have size 0 and are empty. `rspDone` is low and `reqReady` is high, and any allocation answers with `rspErr`=1 until a size has been loaded.
- R2: While `sizeLoad` is high, `reqReady` is low. On that edge, each pool with no slice in use takes its size input.
- R3: An allocation grants the lowest-numbered free usable slice. It answers `rspErr`=0, `rspDblFree`=0 and `rspWord` = {16'd2048, index*2048}, with the size in bits 31:16 and the base in bits 15:0.
- R4: The usable slice count is min(size/2048, 32). An allocation with every usable slice taken answers `rspErr`=1 and `rspWord`=0, and changes no state.
- R5: The two pools are independent. `reqRx`=0 selects the transmit pool and `reqRx`=1 selects the receive pool, and a request touches only the selected pool.
- R6: A release (`reqFree`=1) whose base (bits 15:0) is below the pool size and whose slice base/2048 is held clears that slice. It answers `rspErr`=0 and echoes the request word on `rspWord`.
- R7: A release whose base is not below the pool size answers `rspErr`=1 and changes no state.
- R8: A release of an in-range slice that is not held answers `rspDblFree`=1 with `rspErr`=0, and changes no state.
- R9: A size load is ignored for a pool that has any slice in use.
- R10: `rspDone` pulses exactly once, on the cycle after each accepted request. `rspErr` and `rspDblFree` are low whenever `rspDone` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sizeLoad | input | 1 | Load pool sizes from the size inputs |
| txSizeIn | input | 17 | Transmit pool size in bytes |
| rxSizeIn | input | 17 | Receive pool size in bytes |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Request accepted when high with reqValid |
| reqFree | input | 1 | 0 = allocate, 1 = release |
| reqRx | input | 1 | 0 = transmit pool, 1 = receive pool |
| reqWord | input | 32 | Carveout word for a release |
| rspDone | output | 1 | Response strobe |
| rspErr | output | 1 | Busy (allocate) or base out of range (release) |
| rspDblFree | output | 1 | Release of a slice not held |
| rspWord | output | 32 | Granted carveout word, or echoed release word |

## Verification
A wrong bitmap bit does not show up at once. It first appears when the search reaches that slice: a duplicate grant, a skipped offset, an early busy, or a stray double-release flag. The bench therefore fills pools to exhaustion and refills released holes, so that a corrupted bit shows within a few requests. A wrong size register is exposed when a release at the pool boundary is answered differently, or when the busy point moves.

// File: rtl/carveout_pkg.sv
package carveout_pkg;
  localparam int BLOCK_BYTES = 2048;
  localparam int FIELD_W     = 16;
  localparam int WORD_W      = 2 * FIELD_W;
  localparam int SIZE_W      = FIELD_W + 1;
  localparam int OFF_W       = $clog2(BLOCK_BYTES);
  localparam int MAX_BLOCKS  = (1 << FIELD_W) / BLOCK_BYTES;
  localparam int IDX_W       = $clog2(MAX_BLOCKS);
  localparam int RAW_W       = SIZE_W - OFF_W;
  localparam int NPOOLS      = 2;

  typedef struct packed {
    logic doAlloc;
    logic doFree;
    logic poolRx;
    logic doLoad;
  } ctrlStrobe_t;
endpackage

// File: rtl/ca_pool.sv
module ca_pool
  import carveout_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel,
  input  ctrlStrobe_t        strobe,
  input  logic [SIZE_W-1:0]  sizeIn,
  input  logic [FIELD_W-1:0] freeBase,
  output logic               grantOk,
  output logic [IDX_W-1:0]   grantIdx,
  output logic               freeInRange,
  output logic               freeWasSet
);
  logic [SIZE_W-1:0]     sizeQ;
  logic [MAX_BLOCKS-1:0] mapQ;
  logic [MAX_BLOCKS-1:0] availMask;
  logic [MAX_BLOCKS-1:0] openMask;
  logic [RAW_W-1:0]      rawCnt;
  logic [IDX_W-1:0]      freeIdx;

  assign rawCnt = sizeQ[SIZE_W-1:OFF_W];

  // slice i is usable when i < size/2048; the bitmap width caps the count
  for (genvar i = 0; i < MAX_BLOCKS; i++) begin : g_avail
    assign availMask[i] = rawCnt > RAW_W'(i);
  end

  assign openMask = availMask & ~mapQ;
  assign grantOk  = |openMask;

  always_comb begin
    grantIdx = '0;
    for (int i = MAX_BLOCKS - 1; i >= 0; i--) begin
      if (openMask[i]) grantIdx = IDX_W'(i);
    end
  end

  assign freeIdx     = freeBase[FIELD_W-1:OFF_W];
  assign freeInRange = {1'b0, freeBase} < sizeQ;
  assign freeWasSet  = mapQ[freeIdx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mapQ  <= '0;
      sizeQ <= '0;
    end else begin
      if (sel && strobe.doAlloc && grantOk) mapQ[grantIdx] <= 1'b1;
      if (sel && strobe.doFree && freeInRange && freeWasSet) mapQ[freeIdx] <= 1'b0;
      if (strobe.doLoad && (mapQ == '0)) sizeQ <= sizeIn;
    end
  end
endmodule

// File: rtl/ca_ctrl.sv
module ca_ctrl
  import carveout_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sizeLoad,
  input  logic              reqValid,
  input  logic              reqFree,
  input  logic              reqRx,
  input  logic [WORD_W-1:0] reqWord,
  input  logic              grantOk,
  input  logic [IDX_W-1:0]  grantIdx,
  input  logic              freeInRange,
  input  logic              freeWasSet,
  output logic              reqReady,
  output ctrlStrobe_t       strobe,
  output logic              rspDone,
  output logic              rspErr,
  output logic              rspDblFree,
  output logic [WORD_W-1:0] rspWord
);
  logic accept;

  // a size load wins the cycle; requests wait
  assign reqReady = ~sizeLoad;
  assign accept   = reqValid & reqReady;

  assign strobe.doAlloc = accept & ~reqFree;
  assign strobe.doFree  = accept & reqFree;
  assign strobe.poolRx  = reqRx;
  assign strobe.doLoad  = sizeLoad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rspDone    <= 1'b0;
      rspErr     <= 1'b0;
      rspDblFree <= 1'b0;
      rspWord    <= '0;
    end else begin
      rspDone    <= accept;
      rspErr     <= 1'b0;
      rspDblFree <= 1'b0;
      rspWord    <= '0;
      if (strobe.doAlloc) begin
        rspErr <= ~grantOk;
        if (grantOk) rspWord <= {FIELD_W'(BLOCK_BYTES), grantIdx, OFF_W'(0)};
      end else if (strobe.doFree) begin
        rspErr     <= ~freeInRange;
        rspDblFree <= freeInRange & ~freeWasSet;
        rspWord    <= reqWord;
      end
    end
  end
endmodule

// File: rtl/carveout_alloc.sv
module carveout_alloc
  import carveout_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sizeLoad,
  input  logic [16:0]       txSizeIn,
  input  logic [16:0]       rxSizeIn,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqFree,
  input  logic              reqRx,
  input  logic [31:0]       reqWord,
  output logic              rspDone,
  output logic              rspErr,
  output logic              rspDblFree,
  output logic [31:0]       rspWord
);
  ctrlStrobe_t      strobe;
  logic [SIZE_W-1:0] poolSize [NPOOLS];
  logic             pGrantOk [NPOOLS];
  logic [IDX_W-1:0] pGrantIdx [NPOOLS];
  logic             pInRange [NPOOLS];
  logic             pWasSet [NPOOLS];

  assign poolSize[0] = txSizeIn;
  assign poolSize[1] = rxSizeIn;

  for (genvar p = 0; p < NPOOLS; p++) begin : g_pool
    ca_pool u_pool (
      .clk        (clk),
      .rst_n      (rst_n),
      .sel        (strobe.poolRx == 1'(p)),
      .strobe     (strobe),
      .sizeIn     (poolSize[p]),
      .freeBase   (reqWord[FIELD_W-1:0]),
      .grantOk    (pGrantOk[p]),
      .grantIdx   (pGrantIdx[p]),
      .freeInRange(pInRange[p]),
      .freeWasSet (pWasSet[p])
    );
  end

  ca_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .sizeLoad   (sizeLoad),
    .reqValid   (reqValid),
    .reqFree    (reqFree),
    .reqRx      (reqRx),
    .reqWord    (reqWord),
    .grantOk    (pGrantOk[reqRx]),
    .grantIdx   (pGrantIdx[reqRx]),
    .freeInRange(pInRange[reqRx]),
    .freeWasSet (pWasSet[reqRx]),
    .reqReady   (reqReady),
    .strobe     (strobe),
    .rspDone    (rspDone),
    .rspErr     (rspErr),
    .rspDblFree (rspDblFree),
    .rspWord    (rspWord)
  );
endmodule

// File: rtl/carveout_alloc_chk.sv
module carveout_alloc_chk
  import carveout_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        sizeLoad,
  input logic        reqValid,
  input logic        reqReady,
  input logic        reqFree,
  input logic [31:0] reqWord,
  input logic        rspDone,
  input logic        rspErr,
  input logic        rspDblFree,
  input logic [31:0] rspWord
);
  p_load_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sizeLoad |-> !reqReady);

  p_rsp_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqReady) |=> rspDone);

  p_no_stray_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(reqValid && reqReady) |=> !rspDone);

  p_quiet_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rspDone |-> (!rspErr && !rspDblFree));

  p_grant_shape_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rspDone && !rspErr && !$past(reqFree)) |->
      (rspWord[31:16] == 16'(BLOCK_BYTES) && rspWord[OFF_W-1:0] == '0 && !rspDblFree));

  p_busy_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rspDone && rspErr && !$past(reqFree)) |-> (rspWord == '0));

  p_free_echo_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rspDone && $past(reqFree)) |-> (rspWord == $past(reqWord)));

  p_dbl_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rspDblFree |-> (rspDone && !rspErr));
endmodule

bind carveout_alloc carveout_alloc_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sizeLoad  (sizeLoad),
  .reqValid  (reqValid),
  .reqReady  (reqReady),
  .reqFree   (reqFree),
  .reqWord   (reqWord),
  .rspDone   (rspDone),
  .rspErr    (rspErr),
  .rspDblFree(rspDblFree),
  .rspWord   (rspWord)
);

// File: tb/carveout_alloc_test.sv
`timescale 1ns/1ps
module carveout_alloc_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sizeLoad = 1'b0;
  logic [16:0] txSizeIn = '0;
  logic [16:0] rxSizeIn = '0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqFree = 1'b0;
  logic        reqRx = 1'b0;
  logic [31:0] reqWord = '0;
  logic        rspDone;
  logic        rspErr;
  logic        rspDblFree;
  logic [31:0] rspWord;

  always #2 clk = ~clk;

  carveout_alloc uut (.*);

  typedef struct packed {
    logic        err;
    logic        dbl;
    logic [31:0] word;
  } exp_t;

  exp_t  expQ[$];
  string tagQ[$];
  int    nChk = 0;
  int    nFail = 0;
  logic [31:0] mMap [2];
  int          mSize [2];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input bit fr, input bit rx, input logic [31:0] w, input string tag);
    exp_t e;
    int   cnt;
    int   idx;
    logic [15:0] base;
    e = '0;
    if (!fr) begin
      cnt = mSize[rx] / 2048;
      if (cnt > 32) cnt = 32;
      idx = -1;
      for (int i = cnt - 1; i >= 0; i--) if (!mMap[rx][i]) idx = i;
      if (idx < 0) e.err = 1'b1;
      else begin
        e.word = {16'd2048, 16'(idx * 2048)};
        mMap[rx][idx] = 1'b1;
      end
    end else begin
      base   = w[15:0];
      e.word = w;
      if (int'(base) >= mSize[rx]) e.err = 1'b1;
      else if (!mMap[rx][base / 2048]) e.dbl = 1'b1;
      else mMap[rx][base / 2048] = 1'b0;
    end
    @(negedge clk);
    expQ.push_back(e);
    tagQ.push_back(tag);
    reqValid = 1'b1;
    reqFree  = fr;
    reqRx    = rx;
    reqWord  = w;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic loadSizes(input int tx, input int rx);
    @(negedge clk);
    sizeLoad = 1'b1;
    txSizeIn = 17'(tx);
    rxSizeIn = 17'(rx);
    #1 chk(reqReady == 1'b0, "R2 ready low during load", 64'(reqReady), 64'd0);
    @(negedge clk);
    sizeLoad = 1'b0;
    if (mMap[0] == 0) mSize[0] = tx;
    if (mMap[1] == 0) mSize[1] = rx;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (rspDone) begin
        if (expQ.size() == 0) chk(1'b0, "R10 unexpected response", 64'(rspWord), 64'd0);
        else begin
          exp_t  e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          chk({rspErr, rspDblFree, rspWord} == e, t, 64'({rspErr, rspDblFree, rspWord}), 64'(e));
        end
      end else if (rspErr || rspDblFree) begin
        chk(1'b0, "R10 flags without done", 64'({rspErr, rspDblFree}), 64'd0);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 64'd0, 64'd1);
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    mMap[0] = '0; mMap[1] = '0;
    mSize[0] = 0; mSize[1] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rspDone == 1'b0, "R1 done low after reset", 64'(rspDone), 64'd0);
    chk(reqReady == 1'b1, "R1 ready high after reset", 64'(reqReady), 64'd1);
    issue(1'b0, 1'b0, '0, "R1 alloc before size load is busy");

    loadSizes(8192, 65536);
    for (int i = 0; i < 4; i++) issue(1'b0, 1'b0, '0, "R3 lowest free tx slice");
    issue(1'b0, 1'b0, '0, "R4 tx pool exhausted");
    issue(1'b0, 1'b1, '0, "R5 rx pool independent of tx");
    issue(1'b1, 1'b0, 32'h0800_0800, "R6 release tx slice 1");
    issue(1'b0, 1'b0, '0, "R3 refill lowest hole");
    issue(1'b1, 1'b0, 32'h0800_2000, "R7 base equal to pool size");
    issue(1'b1, 1'b1, 32'h0800_1000, "R8 release of unheld rx slice");

    loadSizes(4096, 2048);
    issue(1'b1, 1'b0, 32'h0800_1800, "R9 tx size kept while in use");
    issue(1'b1, 1'b1, 32'h0800_1000, "R9 rx size kept while in use");

    issue(1'b1, 1'b0, 32'h0800_0000, "R6 release tx slice 0");
    issue(1'b1, 1'b0, 32'h0800_0800, "R6 release tx slice 1");
    issue(1'b1, 1'b0, 32'h0800_1000, "R6 release tx slice 2");
    loadSizes(100000, 4096);
    for (int i = 0; i < 32; i++) issue(1'b0, 1'b0, '0, "R4 capped tx fill");
    issue(1'b0, 1'b0, '0, "R4 busy past 32 slices");
    issue(1'b0, 1'b1, '0, "R5 rx second slice");

    repeat (3) @(negedge clk);
    chk(expQ.size() == 0, "R10 every request answered", 64'(expQ.size()), 64'd0);
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule